// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a system that must be reset if its software stops running. A 12-bit down-counter is stepped by a prescaled version of a free-running tick input. Software controls the block only by writing 16-bit key codes to a key register. One code starts the timer. One code refreshes the counter. One code opens the prescaler and reload registers for writing, and one closes them again. An unexpected value written to the key register has no effect. Once the timer runs, software cannot stop it.

When the counter reaches zero on a prescaled tick, the block raises a reset request for one clock cycle and loads the counter again from the reload value. A changed prescaler or reload value does not take effect at once. It is staged first, and a status flag shows that the update is pending until a fixed number of prescaled ticks have passed. The tick input is a strobe that is synchronous to the block clock.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0, the key register reads 0, `rst_req` is low and the timer is stopped.
- R2: Key 0x5555 opens the prescaler and reload registers for writing, and key 0x0000 closes them. While they are closed, writes to them leave the readback unchanged.
- R3: Prescaler code c (bits 2:0 of offset 1) divides the tick by 4·2^c. Code 7 divides by 256, the same as code 6. While running with no refresh, reset requests repeat every (reload+1)·divider ticks.
- R4: Key 0xCCCC starts the timer and loads the counter from the active reload value. Before the timer starts, no reset request is raised. No key write stops a running timer.
- R5: Key 0xAAAA loads the counter from the active reload value and also closes the prescaler and reload registers. Refreshing often enough prevents any reset request.
- R6: A prescaled tick that finds the running counter at zero raises `rst_req` for exactly one clock cycle and reloads the counter.
- R7: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. Each flag clears after 2 (SYNC_TICKS) prescaled ticks. Only then does the new value reach the counter or the divider.
- R8: The prescaler and the counter advance only in cycles where `tick_in` is high.
- R9: The register offsets are 0 key (write-only, reads 0), 1 prescaler (3 bits), 2 reload (12 bits, upper data bits dropped) and 3 status (read-only, writes ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Free-running tick strobe that feeds the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
A wrong lock state shows up on the next register readback. A wrong count or a wrong divider shows up in the spacing of reset requests, which is measured exactly to the clock cycle. A busy flag that never clears shows on the status register within a few prescaled ticks. A running flag that is lost or set by mistake shows as missing or spurious reset requests within one timeout period.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int KWD_CNT_W  = 12;
    localparam int KWD_KEY_W  = 16;
    localparam int KWD_PSC_W  = 3;
    localparam int KWD_ADDR_W = 2;

    typedef enum logic [KWD_ADDR_W-1:0] {
        SEL_KEY = 2'd0,
        SEL_PSC = 2'd1,
        SEL_RLD = 2'd2,
        SEL_STS = 2'd3
    } reg_sel_e;

    localparam logic [KWD_KEY_W-1:0] CODE_RUN  = 16'hCCCC;
    localparam logic [KWD_KEY_W-1:0] CODE_FEED = 16'hAAAA;
    localparam logic [KWD_KEY_W-1:0] CODE_OPEN = 16'h5555;
    localparam logic [KWD_KEY_W-1:0] CODE_SHUT = 16'h0000;
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
    parameter int PSC_W     = 3,
    parameter int MAX_CODE  = 6,
    parameter int BASE_LOG2 = 2,
    localparam int DIV_W    = BASE_LOG2 + MAX_CODE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic [PSC_W-1:0] code,
    output logic             presc_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [PSC_W-1:0] code_eff;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;
    logic             wrap;
    int               shamt;

    always_comb begin
        // codes above the largest defined one saturate at that divider
        code_eff   = (code > PSC_W'(MAX_CODE)) ? PSC_W'(MAX_CODE) : code;
        shamt      = BASE_LOG2 + int'(code_eff);
        span       = ((DIV_W+1)'(1) << shamt) - (DIV_W+1)'(1);
        limit      = span[DIV_W-1:0];
        // >= keeps the phase bounded after a switch to a smaller divider
        wrap       = (st_q.phase >= limit);
        presc_tick = tick_in && wrap;
        st_d       = st_q;
        if (tick_in) begin
            st_d.phase = wrap ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/kwd_config.sv
module kwd_config
    import kwd_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int PSC_W      = 3,
    parameter int KEY_W      = 16,
    parameter int SYNC_TICKS = 2,
    localparam int SYNC_W    = $clog2(SYNC_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [KEY_W-1:0] bus_wdata,
    input  logic             presc_tick,
    output logic             start_key,
    output logic             feed_key,
    output logic             unlocked,
    output logic [PSC_W-1:0] psc_reg,
    output logic [CNT_W-1:0] rld_reg,
    output logic [PSC_W-1:0] psc_act,
    output logic [CNT_W-1:0] rld_act,
    output logic             psc_busy,
    output logic             rld_busy
);
    typedef struct packed {
        logic              open;
        logic [PSC_W-1:0]  psc_stage;
        logic [CNT_W-1:0]  rld_stage;
        logic [PSC_W-1:0]  psc_live;
        logic [CNT_W-1:0]  rld_live;
        logic              psc_pend;
        logic              rld_pend;
        logic [SYNC_W-1:0] psc_wait;
        logic [SYNC_W-1:0] rld_wait;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic key_hit, psc_hit, rld_hit;
    logic open_key, shut_key;

    always_comb begin
        key_hit   = bus_wr && (reg_sel_e'(bus_addr) == SEL_KEY);
        psc_hit   = bus_wr && (reg_sel_e'(bus_addr) == SEL_PSC) && st_q.open;
        rld_hit   = bus_wr && (reg_sel_e'(bus_addr) == SEL_RLD) && st_q.open;
        start_key = key_hit && (bus_wdata == CODE_RUN);
        feed_key  = key_hit && (bus_wdata == CODE_FEED);
        open_key  = key_hit && (bus_wdata == CODE_OPEN);
        shut_key  = key_hit && (bus_wdata == CODE_SHUT);

        st_d = st_q;
        if (open_key)                 st_d.open = 1'b1;
        else if (shut_key || feed_key) st_d.open = 1'b0;

        // prescaler staging: a new write restarts the settling window
        if (psc_hit) begin
            st_d.psc_stage = bus_wdata[PSC_W-1:0];
            st_d.psc_pend  = 1'b1;
            st_d.psc_wait  = '0;
        end else if (st_q.psc_pend && presc_tick) begin
            if (st_q.psc_wait == SYNC_W'(SYNC_TICKS - 1)) begin
                st_d.psc_live = st_q.psc_stage;
                st_d.psc_pend = 1'b0;
            end else begin
                st_d.psc_wait = st_q.psc_wait + 1'b1;
            end
        end

        // reload staging
        if (rld_hit) begin
            st_d.rld_stage = bus_wdata[CNT_W-1:0];
            st_d.rld_pend  = 1'b1;
            st_d.rld_wait  = '0;
        end else if (st_q.rld_pend && presc_tick) begin
            if (st_q.rld_wait == SYNC_W'(SYNC_TICKS - 1)) begin
                st_d.rld_live = st_q.rld_stage;
                st_d.rld_pend = 1'b0;
            end else begin
                st_d.rld_wait = st_q.rld_wait + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.rld_stage <= '1;
            st_q.rld_live  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked = st_q.open;
    assign psc_reg  = st_q.psc_stage;
    assign rld_reg  = st_q.rld_stage;
    assign psc_act  = st_q.psc_live;
    assign rld_act  = st_q.rld_live;
    assign psc_busy = st_q.psc_pend;
    assign rld_busy = st_q.rld_pend;
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             presc_tick,
    input  logic             start_key,
    input  logic             feed_key,
    input  logic [CNT_W-1:0] rld_act,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             rst_req
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (feed_key) begin
            // refresh outranks a tick in the same cycle
            st_d.cnt = rld_act;
        end else if (start_key && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = rld_act;
        end else if (st_q.run && presc_tick) begin
            if (st_q.cnt == '0) begin
                st_d.req = 1'b1;
                st_d.cnt = rld_act;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.run;
    assign count   = st_q.cnt;
    assign rst_req = st_q.req;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W      = KWD_CNT_W,
    parameter int PSC_W      = KWD_PSC_W,
    parameter int KEY_W      = KWD_KEY_W,
    parameter int SYNC_TICKS = 2,
    parameter int MAX_CODE   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [KEY_W-1:0] bus_wdata,
    output logic [KEY_W-1:0] bus_rdata,
    output logic             rst_req
);
    logic             presc_tick;
    logic             start_key, feed_key, unlocked;
    logic [PSC_W-1:0] psc_reg, psc_act;
    logic [CNT_W-1:0] rld_reg, rld_act, cnt_val;
    logic             pvu, rvu, running;

    kwd_prescaler #(
        .PSC_W    (PSC_W),
        .MAX_CODE (MAX_CODE),
        .BASE_LOG2(2)
    ) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .code      (psc_act),
        .presc_tick(presc_tick)
    );

    kwd_config #(
        .CNT_W     (CNT_W),
        .PSC_W     (PSC_W),
        .KEY_W     (KEY_W),
        .SYNC_TICKS(SYNC_TICKS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .presc_tick(presc_tick),
        .start_key (start_key),
        .feed_key  (feed_key),
        .unlocked  (unlocked),
        .psc_reg   (psc_reg),
        .rld_reg   (rld_reg),
        .psc_act   (psc_act),
        .rld_act   (rld_act),
        .psc_busy  (pvu),
        .rld_busy  (rvu)
    );

    kwd_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_tick(presc_tick),
        .start_key (start_key),
        .feed_key  (feed_key),
        .rld_act   (rld_act),
        .running   (running),
        .count     (cnt_val),
        .rst_req   (rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            SEL_PSC: bus_rdata[PSC_W-1:0] = psc_reg;
            SEL_RLD: bus_rdata[CNT_W-1:0] = rld_reg;
            SEL_STS: bus_rdata[1:0]       = {rvu, pvu};
            default: bus_rdata            = '0;
        endcase
    end
endmodule

module keyed_watchdog_chk #(
    parameter int CNT_W = 12,
    parameter int KEY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             running,
    input logic [CNT_W-1:0] cnt_val,
    input logic             unlocked,
    input logic             pvu,
    input logic             presc_tick,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [KEY_W-1:0] bus_wdata
);
    assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_req_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(cnt_val) == '0) && $past(presc_tick) && $past(running));

    assert_silent_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rst_req);

    assert_cannot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    assert_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata == 16'h5555) |=> unlocked);

    assert_shut_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata == 16'h0000) |=> !unlocked);

    assert_feed_relocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata == 16'hAAAA) |=> !unlocked);

    assert_locked_write_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !unlocked && !pvu) |=> !pvu);
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .running   (running),
    .cnt_val   (cnt_val),
    .unlocked  (unlocked),
    .pvu       (pvu),
    .presc_tick(presc_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int n_checks = 0;
    int n_errors = 0;
    int req_count = 0;

    keyed_watchdog u_keyed_watchdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_in),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .rst_req  (rst_req)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && rst_req) req_count++;

    // {write, addr, wdata, expected readback of addr}
    localparam logic [34:0] VEC [0:20] = '{
        {1'b0, 2'd1, 16'h0000, 16'h0000},  // R1 prescaler reset
        {1'b0, 2'd2, 16'h0000, 16'h0FFF},  // R1 reload reset
        {1'b0, 2'd3, 16'h0000, 16'h0000},  // R1 status reset
        {1'b0, 2'd0, 16'h0000, 16'h0000},  // R9 key reads 0
        {1'b1, 2'd1, 16'h0005, 16'h0000},  // R2 locked
        {1'b1, 2'd2, 16'h0123, 16'h0FFF},  // R2 locked
        {1'b1, 2'd0, 16'h5555, 16'h0000},  // R2 open
        {1'b1, 2'd1, 16'h0005, 16'h0005},
        {1'b1, 2'd2, 16'h0123, 16'h0123},
        {1'b1, 2'd0, 16'h0000, 16'h0000},  // R2 shut
        {1'b1, 2'd1, 16'h0002, 16'h0005},
        {1'b1, 2'd2, 16'h0456, 16'h0123},
        {1'b1, 2'd0, 16'h5555, 16'h0000},
        {1'b1, 2'd1, 16'h0007, 16'h0007},
        {1'b1, 2'd2, 16'h0FFF, 16'h0FFF},
        {1'b1, 2'd0, 16'hAAAA, 16'h0000},  // R5 feed relocks
        {1'b1, 2'd1, 16'h0001, 16'h0007},
        {1'b1, 2'd0, 16'h5555, 16'h0000},
        {1'b1, 2'd2, 16'hF00A, 16'h000A},  // R9 upper bits dropped
        {1'b1, 2'd1, 16'hFFF9, 16'h0001},  // R9 three bits
        {1'b1, 2'd0, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    // cycles from the current negedge until rst_req is seen high
    task automatic wait_req(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            if (rst_req) break;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual hung, expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int n, snap;
        idle(3);
        rst_n = 1'b1;
        check("R1 rst_req low", 32'(rst_req), 0);

        for (int i = 0; i < 21; i++) begin
            if (VEC[i][34]) bus_write(VEC[i][33:32], VEC[i][31:16]);
            bus_read(VEC[i][33:32], rd);
            check($sformatf("R2/R9 vector %0d", i), 32'(rd), 32'(VEC[i][15:0]));
        end

        // R9: status write ignored, R1/R4: never started so no request
        do_reset();
        bus_write(2'd3, 16'h0003);
        bus_read(2'd3, rd);
        check("R9 status write ignored", 32'(rd), 0);

        // R7 flags
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'h0003);
        bus_read(2'd3, rd);
        check("R7 reload flag set", 32'(rd), 2);
        idle(20);
        bus_read(2'd3, rd);
        check("R7 reload flag clears", 32'(rd), 0);

        // R3/R6 period with reload 3, divide by 4
        bus_write(2'd0, 16'hCCCC);
        wait_req(200, n);
        check("R4 start produces request", 32'(rst_req), 1);
        @(negedge clk);
        check("R6 pulse one cycle", 32'(rst_req), 0);
        wait_req(200, n);
        check("R3 R6 interval div4 reload3", 32'(n + 1), 16);

        // R3 code 7 acts as divide by 256
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'h0007);
        bus_read(2'd3, rd);
        check("R7 prescaler flag set", 32'(rd), 1);
        idle(20);
        bus_read(2'd3, rd);
        check("R7 prescaler flag clears", 32'(rd), 0);
        wait_req(3000, n);
        wait_req(3000, n);
        check("R3 interval code7", 32'(n), 1024);

        // R5 refresh prevents timeout and relocks
        do_reset();
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'h0003);
        idle(20);
        bus_write(2'd0, 16'hCCCC);
        snap = req_count;
        for (int i = 0; i < 50; i++) begin
            bus_write(2'd0, 16'hAAAA);
            idle(5);
        end
        check("R5 refresh holds off request", 32'(req_count - snap), 0);
        bus_write(2'd1, 16'h0003);
        bus_read(2'd1, rd);
        check("R5 refresh relocked prescaler", 32'(rd), 0);

        // R4 not started: no request even with reload 0
        do_reset();
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'h0000);
        snap = req_count;
        idle(300);
        check("R4 no request before start", 32'(req_count - snap), 0);

        // R6 reload 0 fires every prescaled tick
        bus_write(2'd0, 16'hCCCC);
        idle(10);
        snap = req_count;
        idle(400);
        n = req_count - snap;
        check("R6 reload0 rate", 32'(n >= 99 && n <= 101), 1);

        // R8 no tick, no progress
        @(negedge clk);
        tick_in = 1'b0;
        idle(3);
        snap = req_count;
        idle(100);
        check("R8 frozen without tick", 32'(req_count - snap), 0);
        tick_in = 1'b1;

        // R4 no key stops it
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'h1234);
        bus_write(2'd0, 16'hCCCC);
        snap = req_count;
        idle(100);
        check("R4 still running after keys", 32'(req_count - snap >= 24), 1);

        // R1 reset stops the timer
        do_reset();
        snap = req_count;
        idle(50);
        check("R1 reset stops requests", 32'(req_count - snap), 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule